// File: doc/BRIEF.md
# Remapping Unit Global Command and Status Control

This block is the global control register set of an address-remapping unit. Software programs two table pointers (a root-table base and an interrupt-remapping table base with a size code). It then turns features on one at a time by writing a command word that is the current status with one extra bit set. Three commands are persistent enables: queued invalidation, DMA remapping and interrupt remapping. Each one becomes a request to the datapath. Its status bit changes only when the datapath reports that the request is done, so software polls status until the bit changes.

Two commands are one-shot: load the root pointer and load the interrupt table pointer. They copy the programmed register into the active pointer that the datapath uses, at the edge of the command write itself. They set no status bit, so software does not wait for them. The block also returns a version word and two capability words as read-only constants. Reads are combinational on the address, and a write takes effect at the clock edge where it is sampled.

Top module: `remap_gcmd_ctrl`

## Requirements
- R1: Register word offsets: 0 version, 1 capability, 2 extended capability, 3 command, 4 status, 5 root pointer, 6 interrupt table pointer. A read of the command offset or of an unmapped offset returns zero. Command and status bit positions: 0 queued invalidation, 1 DMA remapping, 2 interrupt remapping, 3 load root pointer, 4 load interrupt table pointer.
- R2: While reset is applied and after it is released: status reads zero, all enables, requests and load pulses are low, and both active pointers and both programmed pointers are zero.
- R3: The version and capability offsets read back their parameter values, and a write to them changes nothing.
- R4: A command write whose persistent bit differs from the matching status bit raises chg_req_o for that bit from the next cycle, with chg_val_o holding the new value. The status bit does not change until done.
- R5: When chg_done_i is sampled high while that bit's request is pending, the status bit and en_o take the target value on the next cycle and the request drops. chg_done_i with no pending request is ignored.
- R6: While a bit's request is pending, further command writes do not change that bit's target value.
- R7: A command write whose persistent bit equals the current status raises no request.
- R8: Writing a persistent bit clear while its status is set issues a request with value 0. The status and enable stay set until done, then clear.
- R9: A command write with bit 3 set makes root_ptr_o equal to the programmed root register with its low 12 bits zero, on the cycle after that write. root_load_o pulses high for exactly that one cycle, and status bits 3 and 4 always read zero.
- R10: Writing a programmed pointer register leaves the active pointer outputs unchanged until the matching load command. The programmed register reads back its full written value.
- R11: A command write with bit 4 set makes irt_base_o equal to the programmed interrupt table register with its low 12 bits zero, and irt_size_o equal to its low 4 bits, on the next cycle. irt_load_o pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access valid |
| bus_we_i | input | 1 | Access is a write |
| bus_addr_i | input | ADDR_W (3) | Register word offset |
| bus_wdata_i | input | DATA_W (64) | Write data |
| bus_rdata_o | output | DATA_W (64) | Read data, combinational on bus_addr_i |
| chg_req_o | output | 3 | Per persistent feature: change request pending |
| chg_val_o | output | 3 | Per persistent feature: requested enable value |
| chg_done_i | input | 3 | Per persistent feature: datapath finished the change |
| en_o | output | 3 | Acknowledged enable state, equal to status bits 2..0 |
| root_load_o | output | 1 | One-cycle pulse when the root pointer is loaded |
| root_ptr_o | output | DATA_W (64) | Active root-table base, page aligned |
| irt_load_o | output | 1 | One-cycle pulse when the interrupt table pointer is loaded |
| irt_base_o | output | DATA_W (64) | Active interrupt table base, page aligned |
| irt_size_o | output | 4 | Active interrupt table size code (entries = 2^(code+1)) |

## Verification
The embedded assertions check, on every cycle, that a pending request holds its target until done and that a status bit moves only on the cycle after a sampled done. They also check that an active pointer changes only after a load command and then equals the programmed value. Only the bench's scenarios can show the software-level behaviour: register decode, constant readback, that a write during a pending change or a write equal to status is ignored, and the full enable sequence in software order (invalidation, root pointer, interrupt pointer, DMA, interrupt remapping) followed by a disable.

// File: rtl/remap_gcmd_pkg.sv
package remap_gcmd_pkg;
  localparam int unsigned NUM_PERSIST = 3;
  localparam int unsigned NUM_CMD     = 5;

  // command / status bit positions
  localparam int unsigned BIT_QINV = 0;
  localparam int unsigned BIT_DMA  = 1;
  localparam int unsigned BIT_INTR = 2;
  localparam int unsigned BIT_ROOT = 3;
  localparam int unsigned BIT_IRT  = 4;

  // register word offsets
  localparam int unsigned OFF_VER  = 0;
  localparam int unsigned OFF_CAP  = 1;
  localparam int unsigned OFF_ECAP = 2;
  localparam int unsigned OFF_CMD  = 3;
  localparam int unsigned OFF_STS  = 4;
  localparam int unsigned OFF_ROOT = 5;
  localparam int unsigned OFF_IRT  = 6;
endpackage

// File: rtl/remap_gcmd_chan.sv
module remap_gcmd_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_wr_i,
  input  logic cmd_bit_i,
  input  logic done_i,
  output logic req_o,
  output logic val_o,
  output logic sts_o
);
  logic pend_q, tgt_q, sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      tgt_q  <= 1'b0;
      sts_q  <= 1'b0;
    end else if (pend_q) begin
      if (done_i) begin
        sts_q  <= tgt_q;
        pend_q <= 1'b0;
      end
    end else if (cmd_wr_i && (cmd_bit_i != sts_q)) begin
      pend_q <= 1'b1;
      tgt_q  <= cmd_bit_i;
    end
  end

  assign req_o = pend_q;
  assign val_o = tgt_q;
  assign sts_o = sts_q;

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !done_i) |=> (pend_q && $stable(tgt_q) && $stable(sts_q)));

  assert_sts_on_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && done_i) |=> (!pend_q && sts_q == $past(tgt_q)));

  assert_sts_only_after_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_q && done_i) |=> $stable(sts_q));

  assert_no_req_when_equal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && cmd_wr_i && cmd_bit_i == sts_q) |=> !pend_q);
endmodule

// File: rtl/remap_gcmd_ptr.sv
module remap_gcmd_ptr #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] prog_o,
  output logic [DATA_W-1:0] act_o,
  output logic              load_o
);
  logic [DATA_W-1:0] prog_q, act_q;
  logic              load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q <= '0;
      act_q  <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= load_i;
      if (wr_i)   prog_q <= wdata_i;
      if (load_i) act_q  <= prog_q;
    end
  end

  assign prog_o = prog_q;
  assign act_o  = act_q;
  assign load_o = load_q;

  assert_load_copies_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (act_q == $past(prog_q) && load_q));

  assert_act_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(act_q) && !load_q));
endmodule

// File: rtl/remap_gcmd_ctrl.sv
module remap_gcmd_ctrl
  import remap_gcmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned SIZE_W    = 4,
  parameter logic [DATA_W-1:0] VER_VAL  = 64'h10,
  parameter logic [DATA_W-1:0] CAP_VAL  = 64'h00D2_0086_2668,
  parameter logic [DATA_W-1:0] ECAP_VAL = 64'h0000_0F0A
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bus_req_i,
  input  logic                   bus_we_i,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic [DATA_W-1:0]      bus_wdata_i,
  output logic [DATA_W-1:0]      bus_rdata_o,
  output logic [NUM_PERSIST-1:0] chg_req_o,
  output logic [NUM_PERSIST-1:0] chg_val_o,
  input  logic [NUM_PERSIST-1:0] chg_done_i,
  output logic [NUM_PERSIST-1:0] en_o,
  output logic                   root_load_o,
  output logic [DATA_W-1:0]      root_ptr_o,
  output logic                   irt_load_o,
  output logic [DATA_W-1:0]      irt_base_o,
  output logic [SIZE_W-1:0]      irt_size_o
);
  localparam logic [DATA_W-1:0] PAGE_MASK = ~((DATA_W'(1) << PAGE_BITS) - DATA_W'(1));

  logic wr, cmd_wr, root_wr, irt_wr;
  logic [NUM_PERSIST-1:0] sts;
  logic [DATA_W-1:0] root_prog, root_act, irt_prog, irt_act, sts_word;

  assign wr      = bus_req_i && bus_we_i;
  assign cmd_wr  = wr && (bus_addr_i == ADDR_W'(OFF_CMD));
  assign root_wr = wr && (bus_addr_i == ADDR_W'(OFF_ROOT));
  assign irt_wr  = wr && (bus_addr_i == ADDR_W'(OFF_IRT));

  for (genvar i = 0; i < NUM_PERSIST; i++) begin : g_chan
    remap_gcmd_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cmd_wr_i  (cmd_wr),
      .cmd_bit_i (bus_wdata_i[i]),
      .done_i    (chg_done_i[i]),
      .req_o     (chg_req_o[i]),
      .val_o     (chg_val_o[i]),
      .sts_o     (sts[i])
    );
  end

  remap_gcmd_ptr #(.DATA_W(DATA_W)) u_root (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .wr_i (root_wr), .wdata_i (bus_wdata_i),
    .load_i (cmd_wr && bus_wdata_i[BIT_ROOT]),
    .prog_o (root_prog), .act_o (root_act), .load_o (root_load_o)
  );

  remap_gcmd_ptr #(.DATA_W(DATA_W)) u_irt (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .wr_i (irt_wr), .wdata_i (bus_wdata_i),
    .load_i (cmd_wr && bus_wdata_i[BIT_IRT]),
    .prog_o (irt_prog), .act_o (irt_act), .load_o (irt_load_o)
  );

  assign en_o       = sts;
  assign root_ptr_o = root_act & PAGE_MASK;
  assign irt_base_o = irt_act & PAGE_MASK;
  assign irt_size_o = irt_act[SIZE_W-1:0];

  // one-shot bits have no status latch
  assign sts_word = DATA_W'(sts);

  always_comb begin
    unique case (bus_addr_i)
      ADDR_W'(OFF_VER):  bus_rdata_o = VER_VAL;
      ADDR_W'(OFF_CAP):  bus_rdata_o = CAP_VAL;
      ADDR_W'(OFF_ECAP): bus_rdata_o = ECAP_VAL;
      ADDR_W'(OFF_STS):  bus_rdata_o = sts_word;
      ADDR_W'(OFF_ROOT): bus_rdata_o = root_prog;
      ADDR_W'(OFF_IRT):  bus_rdata_o = irt_prog;
      default:           bus_rdata_o = '0;
    endcase
  end

  assert_en_rise_after_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_req_o[0] && !chg_done_i[0]) |=> $stable(en_o[0]));

  assert_root_follows_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && bus_wdata_i[BIT_ROOT]) |=> (root_ptr_o == ($past(root_prog) & PAGE_MASK)));

  assert_irt_follows_cmd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && bus_wdata_i[BIT_IRT]) |=>
      (irt_size_o == $past(irt_prog[SIZE_W-1:0]) && irt_base_o == ($past(irt_prog) & PAGE_MASK)));
endmodule

// File: tb/tb_remap_gcmd_ctrl.sv
module tb_remap_gcmd_ctrl;
  localparam logic [63:0] VER  = 64'h10;
  localparam logic [63:0] CAP  = 64'h00D2_0086_2668;
  localparam logic [63:0] ECAP = 64'h0000_0F0A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [63:0] wdata = '0, rdata;
  logic [2:0]  chg_req, chg_val, done = 3'b0, en;
  logic        root_ld, irt_ld;
  logic [63:0] root_ptr, irt_base;
  logic [3:0]  irt_size;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  remap_gcmd_ctrl #(.VER_VAL(VER), .CAP_VAL(CAP), .ECAP_VAL(ECAP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .chg_req_o(chg_req), .chg_val_o(chg_val),
    .chg_done_i(done), .en_o(en), .root_load_o(root_ld), .root_ptr_o(root_ptr),
    .irt_load_o(irt_ld), .irt_base_o(irt_base), .irt_size_o(irt_size)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; addr = 3'd0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    addr = a;
    #1 d = rdata;
    addr = 3'd0;
  endtask

  task automatic pulse_done(input logic [2:0] m);
    @(negedge clk); done = m;
    @(negedge clk); done = 3'b0;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    rd(3'd4, d);            chk("R2 status", d, 0);
    chk("R2 en", 64'(en), 0);
    chk("R2 req", 64'(chg_req), 0);
    chk("R2 loads", 64'({root_ld, irt_ld}), 0);
    chk("R2 root_ptr", root_ptr, 0);
    chk("R2 irt_base", irt_base, 0);
    rd(3'd5, d);            chk("R2 root prog", d, 0);
  endtask

  task automatic t_ro_regs;
    logic [63:0] d;
    rd(3'd0, d); chk("R3 version", d, VER);
    rd(3'd1, d); chk("R3 cap", d, CAP);
    rd(3'd2, d); chk("R3 ecap", d, ECAP);
    wr(3'd0, 64'hFFFF);
    wr(3'd1, 64'h0);
    rd(3'd0, d); chk("R3 version after write", d, VER);
    rd(3'd1, d); chk("R3 cap after write", d, CAP);
    rd(3'd3, d); chk("R1 command reads zero", d, 0);
    rd(3'd7, d); chk("R1 unmapped reads zero", d, 0);
  endtask

  task automatic t_enable_qinv;
    logic [63:0] d;
    wr(3'd3, 64'h1);
    chk("R4 qinv req", 64'(chg_req), 64'h1);
    chk("R4 qinv val", 64'(chg_val[0]), 1);
    rd(3'd4, d); chk("R4 status before done", d, 0);
    repeat (3) @(negedge clk);
    rd(3'd4, d); chk("R4 status held while pending", d, 0);
    chk("R4 en held while pending", 64'(en), 0);
    pulse_done(3'b001);
    rd(3'd4, d); chk("R5 status after done", d, 64'h1);
    chk("R5 en after done", 64'(en), 64'h1);
    chk("R5 req dropped", 64'(chg_req), 0);
    pulse_done(3'b110);
    rd(3'd4, d); chk("R5 stray done ignored", d, 64'h1);
  endtask

  task automatic t_root_latch;
    logic [63:0] d;
    wr(3'd5, 64'h0000_0012_3456_7ABC);
    chk("R10 root_ptr before load", root_ptr, 0);
    rd(3'd5, d); chk("R10 root prog readback", d, 64'h0000_0012_3456_7ABC);
    wr(3'd3, 64'h1 | 64'h8);
    chk("R9 root_ptr masked", root_ptr, 64'h0000_0012_3456_7000);
    chk("R9 root_load pulse", 64'(root_ld), 1);
    chk("R9 no request for one-shot", 64'(chg_req), 0);
    @(negedge clk);
    chk("R9 root_load one cycle", 64'(root_ld), 0);
    rd(3'd4, d); chk("R9 status bit3 clear", d, 64'h1);
    wr(3'd5, 64'h0000_00FF_0000_1000);
    chk("R10 root_ptr unchanged", root_ptr, 64'h0000_0012_3456_7000);
  endtask

  task automatic t_irt_latch;
    logic [63:0] d;
    wr(3'd6, 64'h0000_0000_89AB_C00F);
    chk("R10 irt_base before load", irt_base, 0);
    wr(3'd3, 64'h1 | 64'h10);
    chk("R11 irt_base", irt_base, 64'h0000_0000_89AB_C000);
    chk("R11 irt_size", 64'(irt_size), 64'hF);
    chk("R11 irt_load pulse", 64'(irt_ld), 1);
    rd(3'd4, d); chk("R9 status bit4 clear", d, 64'h1);
  endtask

  task automatic t_dma_pending;
    logic [63:0] d;
    wr(3'd3, 64'h3);
    chk("R4 dma req", 64'(chg_req), 64'h2);
    wr(3'd3, 64'h1);
    chk("R6 target kept while pending", 64'(chg_val[1]), 1);
    chk("R6 still pending", 64'(chg_req), 64'h2);
    pulse_done(3'b010);
    rd(3'd4, d); chk("R6 dma status set", d, 64'h3);
    wr(3'd3, 64'h3);
    chk("R7 no request when equal", 64'(chg_req), 0);
  endtask

  task automatic t_intr_on_off;
    logic [63:0] d;
    wr(3'd3, 64'h7);
    pulse_done(3'b100);
    rd(3'd4, d); chk("R5 intr status set", d, 64'h7);
    wr(3'd3, 64'h3);
    chk("R8 disable req", 64'(chg_req), 64'h4);
    chk("R8 disable val", 64'(chg_val[2]), 0);
    chk("R8 en held before done", 64'(en), 64'h7);
    pulse_done(3'b100);
    rd(3'd4, d); chk("R8 status cleared", d, 64'h3);
    chk("R8 en cleared", 64'(en), 64'h3);
  endtask

  initial begin
    #1;
    t_reset;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ro_regs;
    t_enable_qinv;
    t_root_latch;
    t_irt_latch;
    t_dma_pending;
    t_intr_on_off;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule